// File: doc/BRIEF.md
# Phase-Shifter Control Word Interface

This block is the digital front end of a 4-bit phase shifter with 22.5-degree steps. A mode input chooses one of two ways to set the phase. In serial mode, a 6-bit control word is shifted in most significant bit first, using a clock pin and a data pin. A rising edge on a strobe pin then transfers the word to a held phase register. In parallel mode, the phase follows dedicated data inputs directly.

The strobe, clock and data functions share three pins with the parallel data bits. The lowest phase bit is shared with the strobe pin. The pins are sampled by the block's system clock through a short synchronizer, and their edges are detected in that clock domain.

The two least significant bits of every serial word are dummy bits and are discarded. The last shift stage drives a serial output, so several devices can be daisy-chained. The block also reports the selected phase in hundredths of a degree.

Top module: `phase_ctrl_top`

## Requirements
- R1: With `modeSer` high, `pinA` is the update strobe, `pinB` is the shift clock and `pinC` is the serial data. A serial-mode output change appears within 4 system clocks of the pin edge that causes it.
- R2: Each rising edge of `pinB` shifts `pinC` into a 6-bit word, MSB first. After six shifts, the bits of the word are D6 (first) down to D1 (last).
- R3: A rising edge of `pinA` in serial mode loads `phaseState` with {D6,D5,D4,D3} of the shifted word.
- R4: While `pinA` is high, rising edges of `pinB` shift nothing.
- R5: `serOut` is the data bit that was shifted in six `pinB` edges earlier.
- R6: In serial mode, `phaseState` holds while `pinA` stays low, whatever `pinB` and `pinC` do.
- R7: With `modeSer` low, `phaseState` equals {parHi[2],parHi[1],parHi[0],pinA} combinationally. `pinB` and `pinC` have no effect in this mode.
- R8: D2 and D1 never affect `phaseState`.
- R9: `phaseCentiDeg` = `phaseState` × 2250. The phase weights are 180, 90, 45 and 22.5 degrees, from bit 3 down to bit 0, and 4'b1111 gives 33750.
- R10: While `modeSer` is low, the shift word and the latched state are held. On return to serial mode, the last serially loaded phase and the pending shift contents are restored.
- R11: Reset (`rstN` low) clears the shift word and the latched state to zero, which is the reference phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSer | input | 1 | 1 = serial mode, 0 = parallel mode |
| pinA | input | 1 | Serial: update strobe; parallel: D3 |
| pinB | input | 1 | Serial: shift clock; parallel: D2 (unused) |
| pinC | input | 1 | Serial: data in; parallel: D1 (unused) |
| parHi | input | 3 | Parallel D6, D5, D4 (bit 2 = D6) |
| serOut | output | 1 | Last shift stage, for daisy-chaining |
| phaseState | output | 4 | Phase code to the switch drivers |
| phaseCentiDeg | output | 16 | Phase in hundredths of a degree |

## Verification
Serial words are applied from a table. The table includes codes that set one phase weight at a time, so a swapped or misplaced bit shows up. It also includes all zeros and all ones, and pairs that differ only in their dummy bits, which separates the dummy bits from the phase bits.

Directed sequences cover the remaining behaviour. One toggles the shift clock while the strobe is high, which separates a masked clock from an unmasked one. Another shifts without a strobe, which catches a latch that follows the shift register. Further sequences switch modes in both directions, trace the serial output one stage at a time, and apply reset after a word has been loaded.

// File: rtl/phase_ctrl_pkg.sv
package phase_ctrl_pkg;
  localparam int WORD_W = 6;
  localparam int PHASE_W = 4;
  localparam int DUMMY_W = WORD_W - PHASE_W;
  localparam int DEG_STEP_CENTI = 2250;
  localparam int CENTI_W = 16;
  // pin positions inside the sampled pin vector
  localparam int PIN_LE = 2;
  localparam int PIN_CLK = 1;
  localparam int PIN_DAT = 0;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
    logic serBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/phase_ctrl_ctrl.sv
module phase_ctrl_ctrl
  import phase_ctrl_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeSer,
  input  logic [2:0]   pinsRaw,
  output ctrlStrobes_t strobes,
  output logic         leLevel
);
  logic [2:0] syncQ [SYNC_DEPTH];
  logic [2:0] lastQ;
  logic [2:0] prevQ;

  genvar s;
  generate
    for (s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= pinsRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign lastQ = syncQ[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= lastQ;
  end

  logic sclkRise;
  logic leRise;
  assign sclkRise = lastQ[PIN_CLK] & ~prevQ[PIN_CLK];
  assign leRise   = lastQ[PIN_LE] & ~prevQ[PIN_LE];
  assign leLevel  = lastQ[PIN_LE] | prevQ[PIN_LE];

  always_comb begin
    strobes.shiftEn = modeSer & sclkRise & ~leLevel;
    strobes.latchEn = modeSer & leRise;
    strobes.serBit  = lastQ[PIN_DAT];
  end
endmodule

// File: rtl/phase_ctrl_dp.sv
module phase_ctrl_dp
  import phase_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  output logic [WORD_W-1:0]  shiftWord,
  output logic [PHASE_W-1:0] latchedState,
  output logic               lastStage
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
    end else if (strobes.shiftEn) begin
      shiftWord <= {shiftWord[WORD_W-2:0], strobes.serBit};
    end
  end

  // dummy bits occupy the low DUMMY_W positions and are dropped here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedState <= '0;
    end else if (strobes.latchEn) begin
      latchedState <= shiftWord[WORD_W-1 -: PHASE_W];
    end
  end

  assign lastStage = shiftWord[WORD_W-1];
endmodule

// File: rtl/phase_ctrl_top.sv
module phase_ctrl_top
  import phase_ctrl_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSer,
  input  logic               pinA,
  input  logic               pinB,
  input  logic               pinC,
  input  logic [PHASE_W-2:0] parHi,
  output logic               serOut,
  output logic [PHASE_W-1:0] phaseState,
  output logic [CENTI_W-1:0] phaseCentiDeg
);
  ctrlStrobes_t       strobes;
  logic               leLevel;
  logic [WORD_W-1:0]  shiftWord;
  logic [PHASE_W-1:0] latchedState;
  logic [2:0]         pinsRaw;

  always_comb begin
    pinsRaw = '0;
    pinsRaw[PIN_LE]  = pinA;
    pinsRaw[PIN_CLK] = pinB;
    pinsRaw[PIN_DAT] = pinC;
  end

  phase_ctrl_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSer (modeSer),
    .pinsRaw (pinsRaw),
    .strobes (strobes),
    .leLevel (leLevel)
  );

  phase_ctrl_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .shiftWord    (shiftWord),
    .latchedState (latchedState),
    .lastStage    (serOut)
  );

  assign phaseState    = modeSer ? latchedState : {parHi, pinA};
  assign phaseCentiDeg = CENTI_W'(phaseState * DEG_STEP_CENTI);
endmodule

// File: rtl/phase_ctrl_chk.sv
module phase_ctrl_chk
  import phase_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               modeSer,
  input logic               pinA,
  input logic [PHASE_W-2:0] parHi,
  input logic               leLevel,
  input ctrlStrobes_t       strobes,
  input logic [WORD_W-1:0]  shiftWord,
  input logic [PHASE_W-1:0] latchedState,
  input logic               serOut,
  input logic [PHASE_W-1:0] phaseState,
  input logic [CENTI_W-1:0] phaseCentiDeg
);
  // R4
  clk_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    leLevel |-> !strobes.shiftEn);

  // R6
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchEn |=> $stable(latchedState));

  // R10
  parallel_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeSer |=> $stable(shiftWord));

  // R5
  ser_out_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> serOut == $past(shiftWord[WORD_W-2]));

  // R7
  parallel_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeSer |-> phaseState == {parHi, pinA});

  // R9
  always_comb begin
    centi_decode_chk: assert (phaseCentiDeg == CENTI_W'(phaseState) * CENTI_W'(DEG_STEP_CENTI));
  end
endmodule

bind phase_ctrl_top phase_ctrl_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .modeSer       (modeSer),
  .pinA          (pinA),
  .parHi         (parHi),
  .leLevel       (leLevel),
  .strobes       (strobes),
  .shiftWord     (shiftWord),
  .latchedState  (latchedState),
  .serOut        (serOut),
  .phaseState    (phaseState),
  .phaseCentiDeg (phaseCentiDeg)
);

// File: tb/phase_ctrl_top_tb.sv
module phase_ctrl_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSer = 1'b1;
  logic pinA = 1'b0, pinB = 1'b0, pinC = 1'b0;
  logic [2:0] parHi = 3'b000;
  logic serOut;
  logic [3:0] phaseState;
  logic [15:0] phaseCentiDeg;

  int checks = 0;
  int errors = 0;
  int clkViol = 0;
  int spaceViol = 0;
  realtime lastLeRise = -1.0e9;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .modeSer(modeSer),
    .pinA(pinA), .pinB(pinB), .pinC(pinC), .parHi(parHi),
    .serOut(serOut), .phaseState(phaseState), .phaseCentiDeg(phaseCentiDeg)
  );

  // serial timing monitor: clock edge under strobe, strobe spacing 630 ns
  always @(posedge pinB) if (modeSer && pinA) clkViol++;
  always @(posedge pinA) if (modeSer) begin
    if ($realtime - lastLeRise < 630.0) spaceViol++;
    lastLeRise = $realtime;
  end

  localparam int NVEC = 8;
  localparam logic [5:0] WORDS [NVEC] = '{6'b000000, 6'b000111, 6'b001000, 6'b010001,
                                           6'b100010, 6'b111111, 6'b101011, 6'b000011};
  localparam logic [3:0] EXPS  [NVEC] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd8, 4'd15, 4'd10, 4'd0};

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    pinC = b; waitClk(12);
    pinB = 1'b1; waitClk(12);
    pinB = 1'b0;
  endtask

  task automatic shiftWord6(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) shiftBit(w[i]);
    waitClk(6);
  endtask

  task automatic strobe();
    pinA = 1'b1; waitClk(6);
    pinA = 1'b0; waitClk(130);
  endtask

  initial begin
    waitClk(3);
    // R11: reset state
    check("R11 reset phase", phaseState, 0);
    check("R11 reset serOut", serOut, 0);
    rstN = 1'b1; waitClk(3);

    // R1 R2 R3 R8 R9: table of serial words
    for (int v = 0; v < NVEC; v++) begin
      shiftWord6(WORDS[v]);
      strobe();
      check("R3 R8 serial load", phaseState, EXPS[v]);
      check("R9 centi-degrees", phaseCentiDeg, EXPS[v] * 2250);
    end

    // R1: output change within 4 clocks of the strobe edge
    shiftWord6(6'b010000);
    pinA = 1'b1; waitClk(4);
    check("R1 latency", phaseState, 4);
    pinA = 1'b0; waitClk(130);

    // R6: shifting without a strobe leaves the state alone
    shiftWord6(6'b110000);
    check("R6 hold without strobe", phaseState, 4);

    // R5: serOut is the bit shifted six edges earlier
    shiftWord6(6'b101100);
    check("R5 serOut after word", serOut, 1);
    shiftBit(1'b0); waitClk(6);
    check("R5 serOut next stage", serOut, 0);
    shiftBit(1'b0); waitClk(6);
    check("R5 serOut third stage", serOut, 1);
    shiftWord6(6'b011000);
    strobe();
    check("R2 MSB-first order", phaseState, 6);

    // R4: clock edges while strobe is high shift nothing
    shiftWord6(6'b100100);
    pinA = 1'b1; waitClk(6);
    pinC = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pinB = 1'b1; waitClk(8); pinB = 1'b0; waitClk(8);
    end
    pinA = 1'b0; waitClk(130);
    check("R4 first load", phaseState, 9);
    check("R4 serOut unshifted", serOut, 1);
    strobe();
    check("R4 reload unchanged", phaseState, 9);

    // R7: parallel mode follows parHi and pinA; pinB/pinC ignored
    shiftWord6(6'b001100);
    modeSer = 1'b0;
    parHi = 3'b101; pinA = 1'b1; #1;
    check("R7 parallel 1011", phaseState, 11);
    pinB = 1'b1; pinC = 1'b1; #1;
    check("R7 pinB/pinC ignored", phaseState, 11);
    parHi = 3'b010; pinA = 1'b0; #1;
    check("R7 parallel 0100", phaseState, 4);
    check("R9 parallel centi", phaseCentiDeg, 4 * 2250);
    for (int k = 0; k < 4; k++) begin
      pinA = 1'b1; waitClk(8); pinB = 1'b0; waitClk(8);
      pinA = 1'b0; waitClk(8); pinB = 1'b1; waitClk(8);
    end
    pinB = 1'b0; pinC = 1'b0; pinA = 1'b0; waitClk(10);

    // R10: return to serial restores state and pending shift word
    modeSer = 1'b1; waitClk(10);
    check("R10 latched restored", phaseState, 9);
    check("R10 shift word kept", serOut, 0);
    strobe();
    check("R10 pending word loads", phaseState, 3);

    // R11: reset after a loaded word
    rstN = 1'b0; waitClk(2);
    check("R11 reset clears phase", phaseState, 0);
    rstN = 1'b1; waitClk(3);

    // timing monitor: only the three deliberate masked edges
    check("R4 monitor clock-under-strobe count", clkViol, 3);
    check("R1 monitor strobe spacing", spaceViol, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule